// File: doc/BRIEF.md
# Erasable Memory Device Model with Identifier Readout

This block is a synthesizable behavioural stand-in for a word-wide, electrically programmable read-only memory. A programming controller under test can drive it like the real device. The controller applies active-low chip enable, output enable and program strobe inputs. It also applies two flags that stand for high-voltage conditions: one marks the programming supply as raised, and one marks the identifier-select address line as raised.

The block decodes these controls into one of six modes: standby, output disable, read, program, program verify and identifier readout. Its internal array starts with every bit set after reset, which stands for an erased part. Programming can only clear bits: each program cycle ANDs the applied word into the addressed location. The data bus output is registered, and a separate output-enable signal travels beside it. A high-impedance state therefore shows as `dataOe` low, with `dataOut` forced to zero.

In identifier mode the block returns one of two parameterised 8-bit codes, chosen by address bit 0. The block checks at elaboration that each code has odd parity.

Top module: `eprom_model`

## Requirements
- R1: After reset every array bit reads as one, and during reset `dataOe` is 0 and `dataOut` is 0.
- R2: A program cycle stores the old word ANDed with `dataIn`, so a bit that has been cleared never returns to one.
- R3: A program cycle takes place only when `vppHigh`=1, `ceN`=0 and `pgmN`=0. Under any other combination the array is unchanged.
- R4: With `ceN`=1 no location is written, even when `vppHigh`=1 and `pgmN`=0.
- R5: Read mode (`ceN`=0, `oeN`=0, `vppHigh`=0, `a9High`=0) drives the stored word at `addr` with `dataOe`=1. The result is registered and appears one clock after the inputs are sampled.
- R6: Standby (`ceN`=1) gives `dataOe`=0 and `dataOut`=0 one clock later, whatever `oeN` is.
- R7: Output disable (`ceN`=0, `oeN`=1, and not in program mode) gives `dataOe`=0 and `dataOut`=0.
- R8: With `a9High`=1, `vppHigh`=0, `ceN`=0 and `oeN`=0, the output is an identifier code placed in bits [7:0] with bits [15:8] zero. `addr[0]`=0 selects the maker code (default 8'h2A) and `addr[0]`=1 selects the device code (default 8'hB5). Bit 7 of each code makes the byte's parity odd.
- R9: In identifier mode, if any address bit above bit 0 is one, `dataOut` is all zeros while `dataOe` stays 1.
- R10: Program verify (`vppHigh`=1, `pgmN`=1, `ceN`=0, `oeN`=0) drives the stored word. It takes priority over identifier readout.
- R11: During a program cycle `dataOe` is 0 on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, erases the array |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| pgmN | input | 1 | Program strobe, active low |
| vppHigh | input | 1 | Programming supply at programming level |
| a9High | input | 1 | Identifier-select address line at raised level |
| addr | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Word to program |
| dataOut | output | DATA_W | Registered output word, zero when not driven |
| dataOe | output | 1 | High when the data bus would be driven |

## Verification
Every output result, whether array data, identifier code or the high-impedance state, is due exactly one clock after the controls and address are sampled. A program cycle changes the array at the same edge, so a read in the very next cycle must already show the ANDed word. The bench drives inputs on the falling edge and runs a behavioural model over the inputs present at each rising edge. It compares `dataOut` and `dataOe` at the following falling edge, so each comparison lands on the cycle in which the registered result is valid. Directed sweeps cover erase, AND programming, inhibit, verify priority and the identifier cases; a long mixed stretch of control patterns follows them.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_DISABLE,
    MODE_READ,
    MODE_PROG,
    MODE_VERIFY,
    MODE_IDENT
  } mode_e;

  typedef struct packed {
    logic writeEn;   // AND dataIn into the addressed word
    logic drive;     // output bus is driven next cycle
    logic selIdent;  // drive identifier code instead of array word
  } strobe_t;

endpackage

// File: rtl/eprom_ctrl.sv
module eprom_ctrl
  import eprom_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    oeN,
  input  logic    pgmN,
  input  logic    vppHigh,
  input  logic    a9High,
  output mode_e   mode,
  output strobe_t strb
);

  always_comb begin
    if (ceN)                 mode = MODE_STANDBY;
    else if (vppHigh && !pgmN) mode = MODE_PROG;
    else if (oeN)            mode = MODE_DISABLE;
    else if (vppHigh)        mode = MODE_VERIFY;
    else if (a9High)         mode = MODE_IDENT;
    else                     mode = MODE_READ;
  end

  always_comb begin
    strb = '0;
    unique case (mode)
      MODE_PROG:   strb.writeEn = 1'b1;
      MODE_READ,
      MODE_VERIFY: strb.drive = 1'b1;
      MODE_IDENT: begin
        strb.drive    = 1'b1;
        strb.selIdent = 1'b1;
      end
      default: ;
    endcase
  end

  // R3
  write_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeEn |-> (vppHigh && !ceN && !pgmN));

  // R4
  ce_inhibit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> !strb.writeEn);

endmodule

// File: rtl/eprom_data.sv
module eprom_data
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [7:0] MAKER_ID  = 8'h2A,
  parameter logic [7:0] DEVICE_ID = 8'hB5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int ID_W  = 8;

  if (ADDR_W < 2) begin : g_bad_addr
    $error("ADDR_W must be at least 2");
  end
  if (DATA_W < ID_W) begin : g_bad_data
    $error("DATA_W must hold an identifier byte");
  end
  if (^MAKER_ID != 1'b1) begin : g_bad_maker
    $error("maker identifier lacks odd parity");
  end
  if (^DEVICE_ID != 1'b1) begin : g_bad_device
    $error("device identifier lacks odd parity");
  end

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] idWord;
  logic              idAddrOk;

  assign curWord  = mem[addr];
  assign idAddrOk = (addr[ADDR_W-1:1] == '0);

  always_comb begin
    idWord = '0;
    if (idAddrOk) idWord[ID_W-1:0] = addr[0] ? DEVICE_ID : MAKER_ID;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.writeEn) begin
      mem[addr] <= curWord & dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOe <= strb.drive;
      if (!strb.drive)       dataOut <= '0;
      else if (strb.selIdent) dataOut <= idWord;
      else                    dataOut <= curWord;
    end
  end

  // checker state: previous access
  logic [ADDR_W-1:0] prevAddr;
  logic [DATA_W-1:0] prevWord;
  logic [DATA_W-1:0] prevData;
  logic              prevWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAddr  <= '0;
      prevWord  <= '1;
      prevData  <= '1;
      prevWrite <= 1'b0;
    end else begin
      prevAddr  <= addr;
      prevWord  <= curWord;
      prevData  <= dataIn;
      prevWrite <= strb.writeEn;
    end
  end

  // R2
  bits_never_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mem[prevAddr] & ~prevWord) == '0);

  // R2
  and_program_chk: assert property (@(posedge clk) disable iff (!rstN)
    prevWrite |-> (mem[prevAddr] == (prevWord & prevData)));

  // R8
  ident_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.drive && strb.selIdent && idAddrOk) |=> (^dataOut[ID_W-1:0]));

  // R9
  ident_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.drive && strb.selIdent && !idAddrOk) |=> (dataOe && dataOut == '0));

endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [7:0] MAKER_ID  = 8'h2A,
  parameter logic [7:0] DEVICE_ID = 8'hB5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              vppHigh,
  input  logic              a9High,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  mode_e   mode;
  strobe_t strb;

  eprom_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .oeN     (oeN),
    .pgmN    (pgmN),
    .vppHigh (vppHigh),
    .a9High  (a9High),
    .mode    (mode),
    .strb    (strb)
  );

  eprom_data #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAKER_ID  (MAKER_ID),
    .DEVICE_ID (DEVICE_ID)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

  // R6
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> (!dataOe && dataOut == '0));

  // R7
  disable_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && oeN) |=> !dataOe);

  // R5
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && pgmN) |=> dataOe);

  // R11
  prog_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PROG) |=> !dataOe);

endmodule

// File: tb/eprom_model_bench.sv
module eprom_model_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [7:0] MAKER  = 8'h2A;
  localparam logic [7:0] DEVICE = 8'hB5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ceN = 1'b1, oeN = 1'b1, pgmN = 1'b1;
  logic              vppHigh = 1'b0, a9High = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic              dataOe;

  int errors = 0;
  int checks = 0;
  logic [DATA_W-1:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_model u_eprom_model (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .pgmN(pgmN),
    .vppHigh(vppHigh), .a9High(a9High), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic compare(input logic [DATA_W-1:0] expOut, input logic expOe,
                         input string tag);
    checks++;
    if (dataOut !== expOut || dataOe !== expOe) begin
      errors++;
      $display("FAIL %s: dataOut=%h dataOe=%b expected dataOut=%h dataOe=%b",
               tag, dataOut, dataOe, expOut, expOe);
    end
  endtask

  // One clock: evaluate model on the inputs present at the rising edge,
  // then compare at the next falling edge.
  task automatic tick();
    logic [DATA_W-1:0] expOut;
    logic              expOe;
    string             tag;
    expOut = '0;
    expOe  = 1'b0;
    if (ceN) begin
      tag = "R6 standby";
      if (vppHigh && !pgmN) tag = "R4 inhibit";
    end else if (vppHigh && !pgmN) begin
      tag = "R2/R11 program";
      model[addr] = model[addr] & dataIn;
    end else if (oeN) begin
      tag = "R7 disable";
    end else if (vppHigh) begin
      tag = "R10 verify";
      expOe = 1'b1; expOut = model[addr];
    end else if (a9High) begin
      expOe = 1'b1;
      if (addr[ADDR_W-1:1] != 0) begin
        tag = "R9 ident zero";
      end else begin
        tag = "R8 ident";
        expOut = {8'h00, (addr[0] ? DEVICE : MAKER)};
      end
    end else begin
      tag = "R5/R3 read";
      expOe = 1'b1; expOut = model[addr];
    end
    @(posedge clk);
    @(negedge clk);
    compare(expOut, expOe, tag);
  endtask

  task automatic drive(input logic c, input logic o, input logic p,
                       input logic v, input logic a9,
                       input int a, input logic [DATA_W-1:0] d);
    ceN = c; oeN = o; pgmN = p; vppHigh = v; a9High = a9;
    addr = ADDR_W'(a); dataIn = d;
    tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    compare('0, 1'b0, "R1 reset state");
    rstN = 1'b1;

    // R1: erased array reads all ones
    for (int i = 0; i < DEPTH; i++) drive(0, 0, 1, 0, 0, i, '0);

    // R2: program then AND further
    drive(0, 1, 0, 1, 0, 5, 16'hF0F0);
    drive(0, 0, 1, 0, 0, 5, '0);
    drive(0, 1, 0, 1, 0, 5, 16'h3CFF);
    drive(0, 0, 1, 0, 0, 5, '0);
    // R2: ones in data never set cleared bits
    drive(0, 1, 0, 1, 0, 5, 16'hFFFF);
    drive(0, 0, 1, 0, 0, 5, '0);

    // R4: ce high inhibits program, read back unchanged
    drive(1, 0, 0, 1, 0, 9, 16'h0000);
    drive(0, 0, 1, 0, 0, 9, '0);
    // R3: pgm low without vpp does not write
    drive(0, 0, 0, 0, 0, 10, 16'h0000);
    drive(0, 0, 1, 0, 0, 10, '0);

    // R10: verify after program, with a9 raised (verify wins)
    drive(0, 1, 0, 1, 0, 20, 16'h1234);
    drive(0, 0, 1, 1, 0, 20, '0);
    drive(0, 0, 1, 1, 1, 20, '0);

    // R6: standby with oe low
    drive(1, 0, 1, 0, 0, 20, '0);
    drive(1, 1, 1, 0, 1, 0, '0);
    // R7: output disable
    drive(0, 1, 1, 0, 0, 20, '0);
    // R11: program with oe low still off
    drive(0, 0, 0, 1, 0, 21, 16'hAAAA);

    // R8: identifier pair, R9: other address bits set
    drive(0, 0, 1, 0, 1, 0, '0);
    drive(0, 0, 1, 0, 1, 1, '0);
    drive(0, 0, 1, 0, 1, 2, '0);
    drive(0, 0, 1, 0, 1, 129, '0);
    drive(0, 0, 1, 0, 1, 0, '0);

    // mixed patterns
    for (int n = 0; n < 2000; n++) begin
      logic [5:0] r;
      r = 6'($urandom);
      drive(r[0] & r[1], r[2], r[3], r[4], r[5],
            int'($urandom % 8), DATA_W'($urandom));
    end

    // R1/R2 closing sweep of touched region
    for (int i = 0; i < 32; i++) drive(0, 0, 1, 0, 0, i, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule